// File: doc/BRIEF.md
# RV32 Instruction Decode Stage with Operand Forwarding

This block is the second stage of an in-order 32-bit RISC-V integer pipeline. Each cycle it takes one fetched instruction and the two values read from the register file. It works out the source and destination register indices, builds the sign-extended immediate and classifies the instruction for the execute stage. All of this settles in one cycle, and the results are captured in an output register that feeds the execute stage.

A source register may be written by an instruction that is still in the execute or memory stage. In that case the stage takes the newer value from that stage in place of the register-file value. If the newer value does not exist yet, because a load has not returned or the memory stage is still waiting, the stage raises a combinational stall toward fetch. It then sends a bubble downstream and keeps its output payload unchanged. A redirect flush cancels the instruction being decoded. Encodings that are not legal are passed on with a trap flag. Two parameters turn multiply/divide and atomic decoding on or off.

Top module: `rv_decode_stage`

## Requirements
- R1: While reset is low and after it, until the first accepted instruction, `out_valid_o`, `reg_write_o`, `illegal_o`, `op_a_o`, `op_b_o` and `imm_o` are 0, and `cls_o` is 0 (no-op).
- R2: A valid instruction that is not stalled or flushed shows up on the outputs after the next rising clock edge, with `out_valid_o` = 1 and `funct3_o` = instruction bits [14:12].
- R3: `imm_o` is the sign-extended immediate of the standard RV32 layout for the opcode: I for loads, OP-IMM and JALR; S for stores; B for branches; U for LUI/AUIPC; J for JAL. It is 0 for every other opcode.
- R4: `cls_o` encodes 0 no-op (fence, system, illegal), 1 ALU (OP, OP-IMM, LUI, AUIPC), 2 load, 3 store, 4 branch, 5 jump, 6 multiply/divide and 7 atomic. `reg_write_o` is 1 only for classes that write rd with rd ≠ 0, and `rd_o` is then bits [11:7]; otherwise `rd_o` is 0.
- R5: `op_a_o`/`op_b_o` carry the value of the register named by bits [19:15]/[24:20]. When the execute stage writes that register (`ex_wr_en_i`, `ex_rd_i`), `ex_data_i` replaces the register-file value.
- R6: When only the memory stage writes that register, `mem_data_i` is used. When both stages write it, the execute-stage value wins.
- R7: A source index of 0 always yields operand 0, whatever the register file or either forwarding path presents.
- R8: If a source that the instruction uses matches a pending execute-stage load (`ex_is_load_i`), or matches a memory-stage write that is not ready (`mem_pending_i`) with no execute-stage match, then `stall_o` is 1 in the same cycle. After the edge, `out_valid_o` is 0 and the other outputs hold.
- R9: A register field that the instruction does not use as a source (for example bits [19:15] of LUI) never causes a stall.
- R10: An illegal encoding gives `illegal_o` = 1 with `out_valid_o` = 1, `cls_o` = 0 and `reg_write_o` = 0. Illegal encodings include low opcode bits other than 11, unknown opcodes, and funct3/funct7 values outside the base set.
- R11: With `HAS_M` = 0, OP instructions with funct7 = 0000001 are illegal. With `HAS_A` = 0, every atomic opcode (0101111) is illegal.
- R12: `flush_i` = 1 cancels the instruction being decoded: `stall_o` is 0, and after the edge `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, already synchronized on release |
| in_valid_i | input | 1 | Fetched instruction is valid |
| instr_i | input | 32 | Fetched instruction |
| rf_a_i | input | 32 | Register-file value for bits [19:15] |
| rf_b_i | input | 32 | Register-file value for bits [24:20] |
| flush_i | input | 1 | Redirect: cancel the instruction in decode |
| ex_wr_en_i | input | 1 | Execute-stage instruction writes a register |
| ex_rd_i | input | 5 | Destination of the execute-stage instruction |
| ex_data_i | input | 32 | Result being produced in execute |
| ex_is_load_i | input | 1 | Execute-stage instruction is a load (value not ready) |
| mem_wr_en_i | input | 1 | Memory-stage instruction writes a register |
| mem_rd_i | input | 5 | Destination of the memory-stage instruction |
| mem_data_i | input | 32 | Result available in the memory stage |
| mem_pending_i | input | 1 | Memory-stage value still waiting on memory |
| stall_o | output | 1 | Hold fetch; decode cannot complete this cycle |
| out_valid_o | output | 1 | Registered: execute-stage payload is valid |
| op_a_o | output | 32 | Registered first operand |
| op_b_o | output | 32 | Registered second operand |
| imm_o | output | 32 | Registered sign-extended immediate |
| rs1_o | output | 5 | Registered first source index |
| rs2_o | output | 5 | Registered second source index |
| rd_o | output | 5 | Registered destination index |
| cls_o | output | 3 | Registered instruction class |
| funct3_o | output | 3 | Registered funct3 field |
| reg_write_o | output | 1 | Registered register-write enable |
| illegal_o | output | 1 | Registered illegal-instruction trap flag |

## Verification
The bench builds two copies that share the same stimulus. One uses the default `HAS_M` = 1 and `HAS_A` = 1, so multiply and load-reserved encodings decode as the multiply/divide and atomic classes. The other uses `HAS_M` = 0 and `HAS_A` = 0, so the same encodings must come out as illegal while base encodings stay legal. The default copy also covers forwarding priority, the x0 rule, both stall sources, unused-field immunity and flush.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

  localparam int XLEN = 32;
  localparam int RAW  = 5;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_FENCE  = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
  localparam logic [6:0] OPC_AMO    = 7'b0101111;

  typedef enum logic [2:0] {
    CLS_NOP    = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BRANCH = 3'd4,
    CLS_JUMP   = 3'd5,
    CLS_MULDIV = 3'd6,
    CLS_ATOMIC = 3'd7
  } cls_e;

  typedef enum logic [2:0] {
    FMT_NONE = 3'd0,
    FMT_I    = 3'd1,
    FMT_S    = 3'd2,
    FMT_B    = 3'd3,
    FMT_U    = 3'd4,
    FMT_J    = 3'd5
  } imm_fmt_e;

  typedef struct packed {
    cls_e     cls;
    imm_fmt_e fmt;
    logic     use_a;
    logic     use_b;
    logic     wr;
    logic     illegal;
  } dec_ctrl_t;

  typedef struct packed {
    logic            valid;
    logic [XLEN-1:0] op_a;
    logic [XLEN-1:0] op_b;
    logic [XLEN-1:0] imm;
    logic [RAW-1:0]  rs1;
    logic [RAW-1:0]  rs2;
    logic [RAW-1:0]  rd;
    cls_e            cls;
    logic [2:0]      f3;
    logic            wr;
    logic            illegal;
  } stage_out_t;

endpackage

// File: rtl/rvd_ctrl_dec.sv
module rvd_ctrl_dec
  import rvd_pkg::*;
#(
  parameter int HAS_M = 1,
  parameter int HAS_A = 1
) (
  input  logic [31:0] instr_i,
  output dec_ctrl_t   ctrl_o
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [4:0] f5;
  logic       legal;
  logic       amo_op_ok;
  dec_ctrl_t  c;

  assign opc = instr_i[6:0];
  assign f3  = instr_i[14:12];
  assign f7  = instr_i[31:25];
  assign f5  = instr_i[31:27];

  always_comb begin
    case (f5)
      5'b00010, 5'b00011, 5'b00001, 5'b00000, 5'b00100,
      5'b01100, 5'b01000, 5'b10000, 5'b10100, 5'b11000,
      5'b11100: amo_op_ok = 1'b1;
      default:  amo_op_ok = 1'b0;
    endcase
  end

  always_comb begin
    c         = '0;
    c.cls     = CLS_NOP;
    c.fmt     = FMT_NONE;
    legal     = 1'b0;
    case (opc)
      OPC_LUI, OPC_AUIPC: begin
        legal = 1'b1; c.cls = CLS_ALU; c.fmt = FMT_U; c.wr = 1'b1;
      end
      OPC_JAL: begin
        legal = 1'b1; c.cls = CLS_JUMP; c.fmt = FMT_J; c.wr = 1'b1;
      end
      OPC_JALR: begin
        legal = (f3 == 3'd0); c.cls = CLS_JUMP; c.fmt = FMT_I;
        c.use_a = 1'b1; c.wr = 1'b1;
      end
      OPC_BRANCH: begin
        legal = (f3 != 3'd2) && (f3 != 3'd3); c.cls = CLS_BRANCH;
        c.fmt = FMT_B; c.use_a = 1'b1; c.use_b = 1'b1;
      end
      OPC_LOAD: begin
        legal = (f3 == 3'd0) || (f3 == 3'd1) || (f3 == 3'd2) ||
                (f3 == 3'd4) || (f3 == 3'd5);
        c.cls = CLS_LOAD; c.fmt = FMT_I; c.use_a = 1'b1; c.wr = 1'b1;
      end
      OPC_STORE: begin
        legal = (f3 < 3'd3); c.cls = CLS_STORE; c.fmt = FMT_S;
        c.use_a = 1'b1; c.use_b = 1'b1;
      end
      OPC_OPIMM: begin
        if (f3 == 3'd1)      legal = (f7 == 7'b0000000);
        else if (f3 == 3'd5) legal = (f7 == 7'b0000000) || (f7 == 7'b0100000);
        else                 legal = 1'b1;
        c.cls = CLS_ALU; c.fmt = FMT_I; c.use_a = 1'b1; c.wr = 1'b1;
      end
      OPC_OP: begin
        c.cls = CLS_ALU; c.use_a = 1'b1; c.use_b = 1'b1; c.wr = 1'b1;
        if (f7 == 7'b0000000)      legal = 1'b1;
        else if (f7 == 7'b0100000) legal = (f3 == 3'd0) || (f3 == 3'd5);
        else if (f7 == 7'b0000001) begin
          legal = (HAS_M != 0); c.cls = CLS_MULDIV;
        end
      end
      OPC_FENCE, OPC_SYSTEM: begin
        legal = 1'b1;
      end
      OPC_AMO: begin
        legal = (HAS_A != 0) && (f3 == 3'd2) && amo_op_ok &&
                ((f5 != 5'b00010) || (instr_i[24:20] == 5'd0));
        c.cls = CLS_ATOMIC; c.use_a = 1'b1; c.use_b = (f5 != 5'b00010);
        c.wr = 1'b1;
      end
      default: legal = 1'b0;
    endcase
    if (instr_i[1:0] != 2'b11) legal = 1'b0;
    if (!legal) begin
      c         = '0;
      c.cls     = CLS_NOP;
      c.fmt     = FMT_NONE;
      c.illegal = 1'b1;
    end
    if (instr_i[11:7] == 5'd0) c.wr = 1'b0;
    ctrl_o = c;
  end

endmodule

// File: rtl/rvd_imm_gen.sv
module rvd_imm_gen
  import rvd_pkg::*;
(
  input  logic [31:0]     instr_i,
  input  imm_fmt_e        fmt_i,
  output logic [XLEN-1:0] imm_o
);

  logic s;
  assign s = instr_i[31];

  always_comb begin
    case (fmt_i)
      FMT_I: imm_o = {{20{s}}, instr_i[31:20]};
      FMT_S: imm_o = {{20{s}}, instr_i[31:25], instr_i[11:7]};
      FMT_B: imm_o = {{19{s}}, s, instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
      FMT_U: imm_o = {instr_i[31:12], 12'd0};
      FMT_J: imm_o = {{11{s}}, s, instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};
      default: imm_o = '0;
    endcase
  end

endmodule

// File: rtl/rvd_fwd_unit.sv
module rvd_fwd_unit #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic          use_i,
  input  logic [DW-1:0] rf_i,
  input  logic          ex_we_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic [DW-1:0] ex_data_i,
  input  logic          ex_late_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic [DW-1:0] mem_data_i,
  input  logic          mem_late_i,
  output logic [DW-1:0] val_o,
  output logic          wait_o
);

  logic nonzero;
  logic ex_hit;
  logic mem_hit;

  assign nonzero = (src_i != '0);
  assign ex_hit  = nonzero && ex_we_i && (ex_rd_i == src_i);
  assign mem_hit = nonzero && mem_we_i && (mem_rd_i == src_i);

  always_comb begin
    if (!nonzero)     val_o = '0;
    else if (ex_hit)  val_o = ex_data_i;
    else if (mem_hit) val_o = mem_data_i;
    else              val_o = rf_i;
  end

  assign wait_o = use_i && (ex_hit ? ex_late_i : (mem_hit && mem_late_i));

endmodule

// File: rtl/rv_decode_stage.sv
module rv_decode_stage
  import rvd_pkg::*;
#(
  parameter int HAS_M = 1,
  parameter int HAS_A = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [31:0] instr_i,
  input  logic [31:0] rf_a_i,
  input  logic [31:0] rf_b_i,
  input  logic        flush_i,
  input  logic        ex_wr_en_i,
  input  logic [4:0]  ex_rd_i,
  input  logic [31:0] ex_data_i,
  input  logic        ex_is_load_i,
  input  logic        mem_wr_en_i,
  input  logic [4:0]  mem_rd_i,
  input  logic [31:0] mem_data_i,
  input  logic        mem_pending_i,
  output logic        stall_o,
  output logic        out_valid_o,
  output logic [31:0] op_a_o,
  output logic [31:0] op_b_o,
  output logic [31:0] imm_o,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic [4:0]  rd_o,
  output logic [2:0]  cls_o,
  output logic [2:0]  funct3_o,
  output logic        reg_write_o,
  output logic        illegal_o
);

  localparam int NSRC = 2;

  dec_ctrl_t       ctrl;
  logic [XLEN-1:0] imm;
  logic [RAW-1:0]  src   [NSRC];
  logic [XLEN-1:0] rfv   [NSRC];
  logic [XLEN-1:0] fwdv  [NSRC];
  logic            usev  [NSRC];
  logic [NSRC-1:0] waitv;
  logic            accept;
  logic            load_en;
  stage_out_t      q_d, q_q;

  assign src[0]  = instr_i[19:15];
  assign src[1]  = instr_i[24:20];
  assign rfv[0]  = rf_a_i;
  assign rfv[1]  = rf_b_i;
  assign usev[0] = ctrl.use_a;
  assign usev[1] = ctrl.use_b;

  rvd_ctrl_dec #(.HAS_M(HAS_M), .HAS_A(HAS_A)) u_ctrl (
    .instr_i (instr_i),
    .ctrl_o  (ctrl)
  );

  rvd_imm_gen u_imm (
    .instr_i (instr_i),
    .fmt_i   (ctrl.fmt),
    .imm_o   (imm)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    rvd_fwd_unit #(.DW(XLEN), .AW(RAW)) u_fwd (
      .src_i      (src[g]),
      .use_i      (usev[g]),
      .rf_i       (rfv[g]),
      .ex_we_i    (ex_wr_en_i),
      .ex_rd_i    (ex_rd_i),
      .ex_data_i  (ex_data_i),
      .ex_late_i  (ex_is_load_i),
      .mem_we_i   (mem_wr_en_i),
      .mem_rd_i   (mem_rd_i),
      .mem_data_i (mem_data_i),
      .mem_late_i (mem_pending_i),
      .val_o      (fwdv[g]),
      .wait_o     (waitv[g])
    );
  end

  assign accept  = in_valid_i && !flush_i;
  assign stall_o = accept && (|waitv);
  assign load_en = accept && !(|waitv);

  // next-state: payload loads only when accepted; valid follows load_en
  always_comb begin
    q_d       = q_q;
    q_d.valid = load_en;
    if (load_en) begin
      q_d.op_a    = fwdv[0];
      q_d.op_b    = fwdv[1];
      q_d.imm     = imm;
      q_d.rs1     = src[0];
      q_d.rs2     = src[1];
      q_d.rd      = ctrl.wr ? instr_i[11:7] : '0;
      q_d.cls     = ctrl.cls;
      q_d.f3      = instr_i[14:12];
      q_d.wr      = ctrl.wr;
      q_d.illegal = ctrl.illegal;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= '0;
      q_q.cls <= CLS_NOP;
    end else begin
      q_q <= q_d;
    end
  end

  assign out_valid_o = q_q.valid;
  assign op_a_o      = q_q.op_a;
  assign op_b_o      = q_q.op_b;
  assign imm_o       = q_q.imm;
  assign rs1_o       = q_q.rs1;
  assign rs2_o       = q_q.rs2;
  assign rd_o        = q_q.rd;
  assign cls_o       = q_q.cls;
  assign funct3_o    = q_q.f3;
  assign reg_write_o = q_q.wr;
  assign illegal_o   = q_q.illegal;

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !flush_i && !stall_o) |=> out_valid_o);

  // R8
  stall_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !out_valid_o);

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ($stable(op_a_o) && $stable(op_b_o) && $stable(imm_o) && $stable(rd_o)));

  // R12
  flush_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !out_valid_o);

  // R12
  flush_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !stall_o);

  // R10
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!reg_write_o && cls_o == 3'd0));

  // R7
  zero_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && rs1_o == 5'd0) |-> (op_a_o == 32'd0));

endmodule

// File: tb/rv_decode_stage_test.sv
module rv_decode_stage_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  // instruction, immediate, class, rd, write enable, illegal (full), illegal (no M/A)
  localparam logic [31:0] T_INSTR [NV] = '{
    32'hFFF08293, 32'h00812303, 32'hFE312E23, 32'h00208863,
    32'h123453B7, 32'hFF9FF0EF, 32'h02C58533, 32'h100322AF,
    32'h00000000, 32'h423100B3, 32'h00000013, 32'h00001217 };
  localparam logic [31:0] T_IMM [NV] = '{
    32'hFFFFFFFF, 32'h00000008, 32'hFFFFFFFC, 32'h00000010,
    32'h12345000, 32'hFFFFFFF8, 32'h00000000, 32'h00000000,
    32'h00000000, 32'h00000000, 32'h00000000, 32'h00001000 };
  localparam logic [2:0] T_CLS [NV] = '{
    3'd1, 3'd2, 3'd3, 3'd4, 3'd1, 3'd5, 3'd6, 3'd7, 3'd0, 3'd0, 3'd1, 3'd1 };
  localparam logic [4:0] T_RD [NV] = '{
    5'd5, 5'd6, 5'd0, 5'd0, 5'd7, 5'd1, 5'd10, 5'd5, 5'd0, 5'd0, 5'd0, 5'd4 };
  localparam logic T_WR [NV] = '{
    1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1 };
  localparam logic T_ILL [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0 };
  localparam logic T_ILL_MIN [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0 };

  logic        clk, rst_n, in_valid, flush;
  logic [31:0] instr, rf_a, rf_b, ex_data, mem_data;
  logic        ex_we, ex_ld, mem_we, mem_pend;
  logic [4:0]  ex_rd, mem_rd;

  logic        stall, ov, rw, ill;
  logic [31:0] opa, opb, imm;
  logic [4:0]  rs1, rs2, rd;
  logic [2:0]  cls, f3;

  logic        m_stall, m_ov, m_rw, m_ill;
  logic [31:0] m_opa, m_opb, m_imm;
  logic [4:0]  m_rs1, m_rs2, m_rd;
  logic [2:0]  m_cls, m_f3;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] held;

  rv_decode_stage uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .instr_i(instr),
    .rf_a_i(rf_a), .rf_b_i(rf_b), .flush_i(flush),
    .ex_wr_en_i(ex_we), .ex_rd_i(ex_rd), .ex_data_i(ex_data), .ex_is_load_i(ex_ld),
    .mem_wr_en_i(mem_we), .mem_rd_i(mem_rd), .mem_data_i(mem_data), .mem_pending_i(mem_pend),
    .stall_o(stall), .out_valid_o(ov), .op_a_o(opa), .op_b_o(opb), .imm_o(imm),
    .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd), .cls_o(cls), .funct3_o(f3),
    .reg_write_o(rw), .illegal_o(ill));

  rv_decode_stage #(.HAS_M(0), .HAS_A(0)) uut_min (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .instr_i(instr),
    .rf_a_i(rf_a), .rf_b_i(rf_b), .flush_i(flush),
    .ex_wr_en_i(ex_we), .ex_rd_i(ex_rd), .ex_data_i(ex_data), .ex_is_load_i(ex_ld),
    .mem_wr_en_i(mem_we), .mem_rd_i(mem_rd), .mem_data_i(mem_data), .mem_pending_i(mem_pend),
    .stall_o(m_stall), .out_valid_o(m_ov), .op_a_o(m_opa), .op_b_o(m_opb), .imm_o(m_imm),
    .rs1_o(m_rs1), .rs2_o(m_rs2), .rd_o(m_rd), .cls_o(m_cls), .funct3_o(m_f3),
    .reg_write_o(m_rw), .illegal_o(m_ill));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet();
    in_valid = 1'b0; flush = 1'b0; instr = 32'h00000013;
    ex_we = 1'b0; ex_ld = 1'b0; ex_rd = 5'd0; ex_data = '0;
    mem_we = 1'b0; mem_pend = 1'b0; mem_rd = 5'd0; mem_data = '0;
  endtask

  task automatic edge_wait();
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    quiet();
    rf_a = 32'hA0A0A0A0; rf_b = 32'h0B0B0B0B;
    rst_n = 1'b0;
    #(CLK_PERIOD * 2 + 3);
    // R1 reset state
    check("R1 valid", {31'd0, ov}, 32'd0);
    check("R1 cls", {29'd0, cls}, 32'd0);
    check("R1 write/illegal", {30'd0, rw, ill}, 32'd0);
    check("R1 operands", opa | opb | imm, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    edge_wait();
    check("R1 idle after release", {31'd0, ov}, 32'd0);

    // R2 R3 R4 R10 R11 table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      quiet();
      in_valid = 1'b1; instr = T_INSTR[i];
      edge_wait();
      check("R2 valid", {31'd0, ov}, 32'd1);
      check("R2 funct3", {29'd0, f3}, {29'd0, T_INSTR[i][14:12]});
      check("R3 imm", imm, T_IMM[i]);
      check("R4 cls", {29'd0, cls}, {29'd0, T_CLS[i]});
      check("R4 rd", {27'd0, rd}, {27'd0, T_RD[i]});
      check("R4 write", {31'd0, rw}, {31'd0, T_WR[i]});
      check("R10 illegal", {31'd0, ill}, {31'd0, T_ILL[i]});
      check("R11 illegal without M/A", {31'd0, m_ill}, {31'd0, T_ILL_MIN[i]});
      check("R5 rf operand a", opa, (T_INSTR[i][19:15] == 5'd0) ? 32'd0 : rf_a);
      if (T_ILL[i]) check("R10 no write", {29'd0, cls, rw} , 32'd0);
    end

    // R5 R6: add x1,x2,x3 with EX and MEM both on x2, MEM alone on x3
    @(negedge clk); quiet();
    in_valid = 1'b1; instr = 32'h003100B3;
    ex_we = 1'b1; ex_rd = 5'd2; ex_data = 32'h00001111;
    mem_we = 1'b1; mem_rd = 5'd2; mem_data = 32'h00002222;
    edge_wait();
    check("R6 EX over MEM", opa, 32'h00001111);
    check("R5 rf b untouched", opb, 32'h0B0B0B0B);
    @(negedge clk);
    ex_rd = 5'd9; mem_rd = 5'd3; mem_data = 32'h00003333;
    edge_wait();
    check("R6 MEM forward b", opb, 32'h00003333);
    check("R5 rf a when no match", opa, 32'hA0A0A0A0);

    // R7: rs1 = x0 with both paths naming x0
    @(negedge clk); quiet();
    in_valid = 1'b1; instr = 32'h003000B3;
    ex_we = 1'b1; ex_rd = 5'd0; ex_data = 32'h55555555;
    mem_we = 1'b1; mem_rd = 5'd0; mem_data = 32'h66666666;
    edge_wait();
    check("R7 x0 operand", opa, 32'd0);

    // R8: load-use on x2 from EX
    @(negedge clk); quiet();
    in_valid = 1'b1; instr = 32'h003100B3; rf_a = 32'hAAAA0001;
    edge_wait();
    held = opa;
    check("R5 preload", held, 32'hAAAA0001);
    @(negedge clk);
    rf_a = 32'hBBBB0002; ex_we = 1'b1; ex_rd = 5'd2; ex_ld = 1'b1;
    #1 check("R8 stall on EX load", {31'd0, stall}, 32'd1);
    edge_wait();
    check("R8 bubble", {31'd0, ov}, 32'd0);
    check("R8 hold operand", opa, held);

    // R8: memory pending on x3, no EX match
    @(negedge clk); quiet();
    in_valid = 1'b1; instr = 32'h003100B3;
    mem_we = 1'b1; mem_rd = 5'd3; mem_pend = 1'b1;
    #1 check("R8 stall on MEM pending", {31'd0, stall}, 32'd1);
    // R6: EX non-load match shadows pending MEM on same register
    ex_we = 1'b1; ex_rd = 5'd3; ex_data = 32'h77777777;
    #1 check("R6 EX shadows pending MEM", {31'd0, stall}, 32'd0);
    edge_wait();
    check("R6 EX value used", opb, 32'h77777777);

    // R9: LUI field bits [19:15] = 8 match an EX load
    @(negedge clk); quiet();
    in_valid = 1'b1; instr = 32'h123453B7;
    ex_we = 1'b1; ex_rd = 5'd8; ex_ld = 1'b1;
    #1 check("R9 unused field no stall", {31'd0, stall}, 32'd0);
    edge_wait();
    check("R9 LUI accepted", {31'd0, ov}, 32'd1);

    // R12: flush cancels, even with a hazard present
    @(negedge clk); quiet();
    in_valid = 1'b1; instr = 32'h003100B3; flush = 1'b1;
    ex_we = 1'b1; ex_rd = 5'd2; ex_ld = 1'b1;
    #1 check("R12 no stall under flush", {31'd0, stall}, 32'd0);
    edge_wait();
    check("R12 flushed bubble", {31'd0, ov}, 32'd0);

    // R2: no valid input gives no output
    @(negedge clk); quiet();
    edge_wait();
    check("R2 idle bubble", {31'd0, ov}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule